// File: doc/BRIEF.md
# Eight-Slot Match Timer Bank

The block is a bank of eight timer slots, numbered 0 to 7, on a simple register bus. Each slot holds a 32-bit match value, a 32-bit count and a control word. The control word picks one of five tick strobes for the slot's count. It also decides whether the slot compares against its own count or against the count of a leader slot, and what happens on a match: clear the count, fire again on later matches, or fire only once. The tick strobes arrive as single-cycle enables in the system clock domain. They are generated outside the block.

Slots 0, 4 and 6 are leaders and always run their own count. Slots 1 to 3 can follow slot 0, slot 5 can follow slot 4, and slot 7 can follow slot 6. A match in an enabled slot sets that slot's status bit. A single interrupt line stays high while any status bit is set. Reading the count of slot 5 or slot 7 can capture the count of its leader into a snapshot register, so that a pair of counts can be read coherently.

Top module: `xtb_bank`

## Requirements
- R1: After reset, every match, count, control, enable, status and snapshot register reads zero, and `irq_o` and `status_o` are low.
- R2: Address map (byte offsets): count of slot s at 0x40+4s, match at 0x80+4s, control at 0xC0+4s, status at 0x14, enable at 0x1C, snapshot at 0x20. Status and enable use data bits 11:4, with slot s at bit s+4. `bus_rdata_o` shows the addressed register in the same cycle, and a write takes effect at the next clock edge.
- R3: Control bits 2:0 select the slot's tick source. Code k in 1..5 picks `tick_i[k-1]`. Codes 0, 6 and 7 stop the count. A running count rises by exactly one per selected strobe, and a stopped count holds its value and stays readable. A software write to a count loads it, and the write wins over a tick in the same cycle.
- R4: A follower slot (1, 2, 3, 5, 7) with control bit 7 clear compares against its leader's count (1-3 use slot 0, 5 uses 4, 7 uses 6). Its own count then stays frozen. Leaders, and followers with bit 7 set, use their own count.
- R5: A slot matches when a tick moves its compare count to a value equal to its match register. A software load of that count does not produce a match. A match sets the slot's status bit only if the slot's enable bit is set.
- R6: With control bit 3 set, a slot on its own count clears that count to zero on the tick that would make it equal the match value.
- R7: With control bit 6 clear, a slot matches once and then stays silent until its match or control register is written. With bit 6 set, it matches every time.
- R8: Slots 0-3 keep control bits 7:0. Slots 4-7 keep control bits 9:0. Higher written bits read back as zero.
- R9: On slots 4-7, control bit 8 holds the slot's own count stopped, whatever the tick code says.
- R10: A read of the count of slot 5 or slot 7, with that slot's control bit 9 set, copies the current count of slot 4 or slot 6 into the snapshot register. With bit 9 clear, the read leaves the snapshot unchanged.
- R11: Writing ones to the status register clears those bits. `irq_o` is high exactly while any status bit is set, and it changes on the same clock edge as the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (drives snapshot capture) |
| bus_addr_i | input | 8 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| tick_i | input | 5 | Single-cycle tick enables, one per source |
| status_o | output | 8 | Per-slot match status, bit s for slot s |
| irq_o | output | 1 | Combined interrupt, high while any status bit is set |

## Verification
The match path is driven with strobes on the selected source, strobes on sources that are not selected, and a load coinciding with a tick. This separates source decoding from counting and from load priority. Followers and leaders are matched together, so that a shared count is shown to reach both slots in the same cycle while the follower's own count stays put. One-shot, repeating, clear-on-match and masked-enable runs reuse the same tick pattern, so any difference between them comes from the control bits alone. Snapshot reads are made with the capture bit both set and clear, and with both follower slots that support it.

// File: rtl/xtb_pkg.sv
package xtb_pkg;

  localparam int N_SLOT   = 8;
  localparam int N_SRC    = 5;
  localparam int CTRL_W   = 10;
  localparam int STAT_LSB = 4;

  // control word bit positions
  localparam int B_CLR    = 3;
  localparam int B_REPEAT = 6;
  localparam int B_OWN    = 7;
  localparam int B_HALT   = 8;
  localparam int B_SNAP   = 9;

  // address groups taken from addr[7:5]
  localparam logic [2:0] G_COUNT = 3'b010;
  localparam logic [2:0] G_MATCH = 3'b100;
  localparam logic [2:0] G_CTRL  = 3'b110;

  localparam logic [7:0] A_STATUS = 8'h14;
  localparam logic [7:0] A_ENABLE = 8'h1C;
  localparam logic [7:0] A_SNAP   = 8'h20;

  // leader slot whose count a follower compares against
  function automatic int leader_of(input int s);
    if (s < 4)      return 0;
    else if (s < 6) return 4;
    else            return 6;
  endfunction

  function automatic bit is_leader(input int s);
    return (s == 0) || (s == 4) || (s == 6);
  endfunction

  function automatic bit keeps_wide(input int s);
    return s >= 4;
  endfunction

  // tick strobe chosen by a 3-bit source code; 0, 6, 7 are idle
  function automatic logic pick_tick(input logic [2:0] code,
                                     input logic [N_SRC-1:0] ticks);
    logic r;
    case (code)
      3'd1:    r = ticks[0];
      3'd2:    r = ticks[1];
      3'd3:    r = ticks[2];
      3'd4:    r = ticks[3];
      3'd5:    r = ticks[4];
      default: r = 1'b0;
    endcase
    return r;
  endfunction

  // follower slots that can trigger a leader snapshot
  function automatic bit snap_reader(input int s);
    return (s == 5) || (s == 7);
  endfunction

endpackage

// File: rtl/xtb_channel.sv
module xtb_channel
  import xtb_pkg::*;
#(
  parameter int SLOT  = 0,
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  tick_i,
  input  logic              wr_match_i,
  input  logic              wr_ctrl_i,
  input  logic              wr_cnt_i,
  input  logic [CNT_W-1:0]  wdata_i,
  input  logic [CNT_W-1:0]  ref_cnt_i,
  input  logic              ref_adv_i,
  input  logic              ref_ld_i,
  output logic [CNT_W-1:0]  match_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              adv_o,
  output logic              ld_o,
  output logic              hit_o
);

  localparam bit WIDE = keeps_wide(SLOT);
  localparam bit LEAD = is_leader(SLOT);
  localparam logic [CTRL_W-1:0] KEEP_MASK = WIDE ? 10'h3FF : 10'h0FF;
  localparam logic [CNT_W-1:0]  ONE = CNT_W'(1);

  logic [CNT_W-1:0]  match_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              armed_q;

  logic              own_mode;
  logic              halted;
  logic [CNT_W-1:0]  cmp_cnt;
  logic              cmp_adv;
  logic              cmp_ld;
  logic              clr_now;

  assign own_mode = LEAD || ctrl_q[B_OWN];
  assign halted   = WIDE && ctrl_q[B_HALT];
  assign adv_o    = own_mode && !halted && pick_tick(ctrl_q[2:0], tick_i);
  assign ld_o     = wr_cnt_i;

  // compare source: own count or the leader's count
  assign cmp_cnt = own_mode ? cnt_q  : ref_cnt_i;
  assign cmp_adv = own_mode ? adv_o  : ref_adv_i;
  assign cmp_ld  = own_mode ? wr_cnt_i : ref_ld_i;

  assign hit_o   = armed_q && cmp_adv && !cmp_ld && ((cmp_cnt + ONE) == match_q);
  assign clr_now = hit_o && own_mode && ctrl_q[B_CLR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_q <= '0;
      ctrl_q  <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else begin
      if (wr_match_i) match_q <= wdata_i;
      if (wr_ctrl_i)  ctrl_q  <= wdata_i[CTRL_W-1:0] & KEEP_MASK;

      if (wr_cnt_i)     cnt_q <= wdata_i;
      else if (clr_now) cnt_q <= '0;
      else if (adv_o)   cnt_q <= cnt_q + ONE;

      if (wr_match_i || wr_ctrl_i)          armed_q <= 1'b1;
      else if (hit_o && !ctrl_q[B_REPEAT])  armed_q <= 1'b0;
    end
  end

  assign match_o = match_q;
  assign cnt_o   = cnt_q;
  assign ctrl_o  = ctrl_q;

  // R7: a one-shot slot is silent on the cycle after it fires
  p_oneshot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && !ctrl_q[B_REPEAT] && !wr_match_i && !wr_ctrl_i) |=> !hit_o);

  // R6: clear-on-match leaves the own count at zero
  p_match_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && own_mode && ctrl_q[B_CLR] && !wr_cnt_i) |=> (cnt_q == '0));

  // R3: without a tick or load the count holds
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_o && !wr_cnt_i) |=> $stable(cnt_q));

  // R3: a tick without load or clear adds exactly one
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_o && !wr_cnt_i && !clr_now) |=> (cnt_q == $past(cnt_q) + ONE));

  generate
    if (WIDE) begin : g_halt_chk
      // R9: the halt bit freezes the own count
      p_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[B_HALT] && !wr_cnt_i) |=> $stable(cnt_q));
    end
  endgenerate

endmodule

// File: rtl/xtb_status.sv
module xtb_status
  import xtb_pkg::*;
#(
  parameter int NS = N_SLOT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] hit_i,
  input  logic          wr_enable_i,
  input  logic          wr_clear_i,
  input  logic [NS-1:0] bits_i,
  output logic [NS-1:0] enable_o,
  output logic [NS-1:0] status_o,
  output logic          irq_o
);

  logic [NS-1:0] en_q;
  logic [NS-1:0] stat_q;
  logic [NS-1:0] stat_n;
  logic          irq_q;
  logic [NS-1:0] set_v;
  logic [NS-1:0] clr_v;

  assign set_v  = hit_i & en_q;
  assign clr_v  = wr_clear_i ? bits_i : '0;
  assign stat_n = (stat_q & ~clr_v) | set_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_enable_i) en_q <= bits_i;
      stat_q <= stat_n;
      irq_q  <= |stat_n;
    end
  end

  assign enable_o = en_q;
  assign status_o = stat_q;
  assign irq_o    = irq_q;

  // R5: an enabled match sets its status bit on the next edge
  generate
    for (genvar i = 0; i < NS; i++) begin : g_set_chk
      p_status_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i[i] && en_q[i]) |=> stat_q[i]);
      p_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_i[i] && !stat_q[i]) |=> !stat_q[i]);
    end
  endgenerate

  // R11: interrupt line tracks the status register
  p_irq_track_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == (|stat_q));

endmodule

// File: rtl/xtb_bank.sv
module xtb_bank
  import xtb_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [CNT_W-1:0]  bus_wdata_i,
  output logic [CNT_W-1:0]  bus_rdata_o,
  input  logic [N_SRC-1:0]  tick_i,
  output logic [N_SLOT-1:0] status_o,
  output logic              irq_o
);

  localparam int SLOT_W = $clog2(N_SLOT);

  logic [CNT_W-1:0]  cnt_w   [N_SLOT];
  logic [CNT_W-1:0]  match_w [N_SLOT];
  logic [CTRL_W-1:0] ctrl_w  [N_SLOT];
  logic [N_SLOT-1:0] adv_w;
  logic [N_SLOT-1:0] ld_w;
  logic [N_SLOT-1:0] hit_w;
  logic [N_SLOT-1:0] en_w;
  logic [N_SLOT-1:0] stat_w;

  logic [2:0]        grp;
  logic [SLOT_W-1:0] slot;
  logic [7:0]        addr8;

  assign addr8 = bus_addr_i[7:0];
  assign grp   = addr8[7:5];
  assign slot  = addr8[2 +: SLOT_W];

  generate
    for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
      localparam int LDR = leader_of(s);
      logic wr_m, wr_c, wr_n;
      assign wr_m = bus_wr_i && (grp == G_MATCH) && (slot == SLOT_W'(s));
      assign wr_c = bus_wr_i && (grp == G_CTRL)  && (slot == SLOT_W'(s));
      assign wr_n = bus_wr_i && (grp == G_COUNT) && (slot == SLOT_W'(s));

      xtb_channel #(.SLOT(s), .CNT_W(CNT_W)) u_chan (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .wr_match_i (wr_m),
        .wr_ctrl_i  (wr_c),
        .wr_cnt_i   (wr_n),
        .wdata_i    (bus_wdata_i),
        .ref_cnt_i  (cnt_w[LDR]),
        .ref_adv_i  (adv_w[LDR]),
        .ref_ld_i   (ld_w[LDR]),
        .match_o    (match_w[s]),
        .cnt_o      (cnt_w[s]),
        .ctrl_o     (ctrl_w[s]),
        .adv_o      (adv_w[s]),
        .ld_o       (ld_w[s]),
        .hit_o      (hit_w[s])
      );
    end
  endgenerate

  xtb_status #(.NS(N_SLOT)) u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .hit_i       (hit_w),
    .wr_enable_i (bus_wr_i && (addr8 == A_ENABLE)),
    .wr_clear_i  (bus_wr_i && (addr8 == A_STATUS)),
    .bits_i      (bus_wdata_i[STAT_LSB +: N_SLOT]),
    .enable_o    (en_w),
    .status_o    (stat_w),
    .irq_o       (irq_o)
  );

  // snapshot of a leader count on a follower count read
  logic [CNT_W-1:0] snap_q;
  logic             snap_take;
  logic [CNT_W-1:0] snap_src;

  always_comb begin
    snap_take = 1'b0;
    snap_src  = cnt_w[4];
    if (bus_rd_i && (grp == G_COUNT)) begin
      for (int s = 0; s < N_SLOT; s++) begin
        if (snap_reader(s) && (slot == SLOT_W'(s)) && ctrl_w[s][B_SNAP]) begin
          snap_take = 1'b1;
          snap_src  = cnt_w[leader_of(s)];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         snap_q <= '0;
    else if (snap_take) snap_q <= snap_src;
  end

  always_comb begin
    bus_rdata_o = '0;
    case (grp)
      G_COUNT: bus_rdata_o = cnt_w[slot];
      G_MATCH: bus_rdata_o = match_w[slot];
      G_CTRL:  bus_rdata_o = CNT_W'(ctrl_w[slot]);
      default: begin
        if (addr8 == A_STATUS)      bus_rdata_o[STAT_LSB +: N_SLOT] = stat_w;
        else if (addr8 == A_ENABLE) bus_rdata_o[STAT_LSB +: N_SLOT] = en_w;
        else if (addr8 == A_SNAP)   bus_rdata_o = snap_q;
      end
    endcase
  end

  assign status_o = stat_w;

  // R10: a capturing read loads the leader count into the snapshot
  p_snapshot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    snap_take |=> (snap_q == $past(snap_src)));

  // R10: without a capturing read the snapshot holds
  p_snap_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_take |=> $stable(snap_q));

  // R4: a follower's shared compare never fires without a leader tick
  p_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_w[1][B_OWN] && !adv_w[0]) |-> !hit_w[1]);

endmodule

// File: tb/xtb_bank_bench.sv
`timescale 1ns/1ps
module xtb_bank_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr, rd;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [4:0]  tick;
  logic [7:0]  status;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  xtb_bank u_xtb_bank (
    .clk(clk), .rst_n(rst_n), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .tick_i(tick), .status_o(status), .irq_o(irq)
  );

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver tasks: start at a falling edge, end at the next one
  task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic do_wr_tick(input logic [7:0] a, input logic [31:0] d, input logic [4:0] m);
    wr = 1'b1; addr = a; wdata = d; tick = m;
    @(negedge clk);
    wr = 1'b0; tick = '0;
  endtask

  task automatic do_tick(input logic [4:0] m, input int n);
    for (int i = 0; i < n; i++) begin
      tick = m;
      @(negedge clk);
      tick = '0;
    end
  endtask

  task automatic do_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    sb.push_back(it);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
  endtask

  // monitor: pops the expected read value shortly after the driver sets it
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rd) begin
        if (sb.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R2: read with no expected item, actual %h expected none", rdata);
        end else begin
          item_t it;
          it = sb.pop_front();
          chk(rdata, it.exp, it.tag);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0; tick = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk({31'd0, irq}, 32'd0, "R1 irq after reset");
    chk({24'd0, status}, 32'd0, "R1 status after reset");
    do_rd(8'h40, 32'd0, "R1 count slot0");
    do_rd(8'h9C, 32'd0, "R1 match slot7");
    do_rd(8'hC0, 32'd0, "R1 control slot0");
    do_rd(8'h14, 32'd0, "R1 status reg");
    do_rd(8'h20, 32'd0, "R1 snapshot");

    // R8 control widths
    do_wr(8'hC0, 32'h3FF);
    do_rd(8'hC0, 32'h0FF, "R8 narrow control");
    do_wr(8'hD4, 32'h3FF);
    do_rd(8'hD4, 32'h3FF, "R8 wide control");
    do_wr(8'hD4, 32'h0);
    do_wr(8'hC0, 32'h0);

    // R3 source select and counting
    do_wr(8'hC0, 32'h1);
    do_tick(5'b00001, 3);
    do_tick(5'b00010, 2);
    do_rd(8'h40, 32'd3, "R3 code1 counts tick0 only");
    do_wr(8'hC0, 32'h4);
    do_tick(5'b01000, 2);
    do_tick(5'b10000, 1);
    do_rd(8'h40, 32'd5, "R3 code4 counts tick3 only");
    do_wr(8'hC0, 32'h5);
    do_tick(5'b10000, 1);
    do_rd(8'h40, 32'd6, "R3 code5 counts tick4");
    do_wr(8'hC0, 32'h6);
    do_tick(5'b11111, 2);
    do_rd(8'h40, 32'd6, "R3 code6 stopped");
    do_wr(8'hC0, 32'h0);
    do_tick(5'b11111, 1);
    do_rd(8'h40, 32'd6, "R3 code0 stopped");
    do_wr(8'h40, 32'd100);
    do_rd(8'h40, 32'd100, "R3 software load");
    do_wr(8'hC0, 32'h1);
    do_wr_tick(8'h40, 32'd7, 5'b00001);
    do_rd(8'h40, 32'd7, "R3 load wins over tick");

    // R4 / R5 shared compare and enabled match
    do_wr(8'h1C, 32'hFF0);
    do_rd(8'h1C, 32'hFF0, "R2 enable reg");
    do_wr(8'h40, 32'd0);
    do_wr(8'h84, 32'd3);
    do_tick(5'b00001, 2);
    chk({24'd0, status}, 32'd0, "R5 no match before value");
    do_tick(5'b00001, 1);
    chk({24'd0, status}, 32'h02, "R4 follower matches leader count");
    chk({31'd0, irq}, 32'd1, "R11 irq on status");
    do_rd(8'h14, 32'h20, "R2 status bit position");
    do_rd(8'h44, 32'd0, "R4 follower own count frozen");

    // R11 clear
    do_wr(8'h14, 32'h20);
    chk({24'd0, status}, 32'd0, "R11 write-one clear");
    chk({31'd0, irq}, 32'd0, "R11 irq drops");

    // R7 one-shot then repeat
    do_wr(8'h40, 32'd0);
    do_tick(5'b00001, 3);
    chk({24'd0, status}, 32'd0, "R7 one-shot silent");
    do_wr(8'hC4, 32'h40);
    do_wr(8'h40, 32'd0);
    do_tick(5'b00001, 3);
    chk({24'd0, status}, 32'h02, "R7 rearmed by control write");
    do_wr(8'h14, 32'h20);
    do_wr(8'h40, 32'd0);
    do_tick(5'b00001, 3);
    chk({24'd0, status}, 32'h02, "R7 repeat fires again");
    do_wr(8'h14, 32'h20);

    // R5 masked by enable
    do_wr(8'h1C, 32'h0);
    do_wr(8'h40, 32'd0);
    do_tick(5'b00001, 3);
    chk({24'd0, status}, 32'd0, "R5 disabled match ignored");
    do_wr(8'h1C, 32'hFF0);
    do_wr(8'hC0, 32'h0);

    // R6 clear on match, leader slot 4
    do_wr(8'hD0, 32'h49);
    do_wr(8'h90, 32'd2);
    do_wr(8'h50, 32'd0);
    do_tick(5'b00001, 1);
    do_rd(8'h50, 32'd1, "R6 count before match");
    do_tick(5'b00001, 1);
    chk({24'd0, status}, 32'h10, "R6 match on slot4");
    do_rd(8'h50, 32'd0, "R6 count cleared on match");
    do_tick(5'b00001, 1);
    do_rd(8'h50, 32'd1, "R6 count restarts");
    do_wr(8'h14, 32'h100);

    // R11 two sources: irq stays while one remains
    do_wr(8'hC0, 32'h1);
    do_wr(8'h40, 32'd0);
    do_wr(8'h84, 32'd1);
    do_tick(5'b00001, 1);
    chk({24'd0, status}, 32'h12, "R11 two slots set together");
    do_wr(8'h14, 32'h20);
    chk({24'd0, status}, 32'h10, "R11 partial clear");
    chk({31'd0, irq}, 32'd1, "R11 irq held by remaining bit");
    do_wr(8'h14, 32'h100);
    chk({31'd0, irq}, 32'd0, "R11 irq low when all clear");
    do_wr(8'hC0, 32'h0);

    // R9 halt bit
    do_wr(8'hD0, 32'h149);
    do_wr(8'h50, 32'd5);
    do_tick(5'b11111, 2);
    do_rd(8'h50, 32'd5, "R9 halt holds count");

    // R10 snapshot
    do_wr(8'hD0, 32'h1);
    do_wr(8'h50, 32'd77);
    do_wr(8'hD4, 32'h200);
    do_rd(8'h54, 32'd0, "R10 follower count read");
    do_rd(8'h20, 32'd77, "R10 snapshot of slot4");
    do_wr(8'h50, 32'd5);
    do_wr(8'hD4, 32'h0);
    do_rd(8'h54, 32'd0, "R10 read without capture");
    do_rd(8'h20, 32'd77, "R10 snapshot unchanged");
    do_wr(8'h58, 32'd9);
    do_wr(8'hDC, 32'h200);
    do_rd(8'h5C, 32'd0, "R10 slot7 count read");
    do_rd(8'h20, 32'd9, "R10 snapshot of slot6");

    @(negedge clk);
    if (sb.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R2: %0d reads unchecked, expected 0", sb.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule